// File: doc/BRIEF.md
# Serial audio frame transmitter

This block is the sending side of a controller on a time-slotted serial audio link. It runs on the link's bit clock and sends a continuous stream of 256-bit frames. Each frame opens with a 16-bit tag slot and is followed by twelve 20-bit data slots. The block drives a frame-sync line and a serial data line, and both change only on the rising edge of the bit clock.

Upstream logic supplies three things: a 12-bit mask of valid slots, twelve 20-bit payloads packed into one flat word, and a 2-bit codec address. The block raises `frameStart` for the single cycle before each frame begins. All inputs are sampled at the rising edge that ends that cycle, so upstream logic can update them freely for the rest of the frame.

The tag slot is built from four parts: a global frame-valid flag, one valid flag per slot, a reserved zero bit and the codec address. The payload of a slot marked invalid is sent as zeros.

Top module: `slot_frame_tx`

## Requirements
- R1: A frame lasts 256 bit clocks. `frameStart` is high for exactly one cycle in every 256: while reset is held, and in the cycle before each frame's first bit is presented, which is the cycle in which the frame's last bit is on the line.
- R2: `syncOut` is high for exactly the 16 bit clocks of the tag slot, starting with the frame's first bit, and low for the 240 bit clocks of the data phase.
- R3: Tag bit 15, the first bit sent in a frame, is the OR of all twelve `slotValid` bits that were captured for that frame.
- R4: Tag bits 14 down to 3 carry `slotValid[0]` through `slotValid[11]` in that order, so data slot n (1..12) has its flag at tag bit 15-n.
- R5: Tag bits 1:0 carry the captured `codecAddr`, and tag bit 2 is always 0.
- R6: Every slot is sent most significant bit first. The tag is sent bit 15 down to 0. Data slot n is sent from `slotData[(n-1)*20 +: 20]`, bit 19 down to 0, immediately after slot n-1.
- R7: All 20 bits of a data slot whose captured valid flag is 0 are sent as 0, whatever its payload input holds.
- R8: `slotValid`, `slotData` and `codecAddr` are captured only at the rising edge where `frameStart` is high. Changes at any other time have no effect on the frame being sent.
- R9: While `rstN` is low, `syncOut` and `dataOut` are 0. The first rising edge after release presents tag bit 15 with `syncOut` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all outputs change on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| slotValid | input | 12 | Valid flag per data slot, bit 0 for slot 1 |
| slotData | input | 240 | Twelve 20-bit payloads, slot 1 in bits 19:0 |
| codecAddr | input | 2 | Codec address placed in tag bits 1:0 |
| frameStart | output | 1 | High in the cycle whose closing edge captures inputs and starts a frame |
| syncOut | output | 1 | Frame sync, high during the tag slot |
| dataOut | output | 1 | Serial frame data, MSB first per slot |

## Verification
Each output bit belongs to the rising edge that presents it. Frame position p (0..255) is on the line from the (p+1)-th edge after the capture edge onward, and `frameStart` rises again after the 256th edge. The bench drives inputs on falling edges and samples sync, data and strobe on the falling edge after each rising edge, so every sample falls half a period after the register that produced it. Sweeps over single-slot masks, full, empty and alternating masks, and input changes in the middle of a frame are compared field by field with frames assembled arithmetically in the bench.

// File: rtl/slot_tx_pkg.sv
package slot_tx_pkg;

  // Strobes from the frame sequencer to the datapath
  typedef struct packed {
    logic load;      // present first frame bit and capture inputs
    logic syncNext;  // sync level for the bit being presented
  } txStrobe_t;

endpackage

// File: rtl/slot_tx_ctrl.sv
module slot_tx_ctrl
  import slot_tx_pkg::*;
#(
  parameter int TAG_W   = 16,
  parameter int FRAME_W = 256
) (
  input  logic      clk,
  input  logic      rstN,
  output txStrobe_t strobe,
  output logic      frameStart
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_W);

  // bitPos = frame position presented at the next rising edge
  logic [CNT_W-1:0] bitPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= '0;
    end else if (bitPos == LAST_POS) begin
      bitPos <= '0;
    end else begin
      bitPos <= bitPos + 1'b1;
    end
  end

  always_comb begin
    strobe.load     = (bitPos == '0);
    strobe.syncNext = (bitPos < TAG_END);
    frameStart      = (bitPos == '0);
  end

endmodule

// File: rtl/slot_tx_dp.sv
module slot_tx_dp
  import slot_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 20,
  parameter int TAG_W     = 16,
  parameter int ADDR_W    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  txStrobe_t                   strobe,
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slotData,
  input  logic [ADDR_W-1:0]           codecAddr,
  output logic                        syncOut,
  output logic                        dataOut
);

  localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int FLAG_HI = TAG_W - 2;

  logic [TAG_W-1:0]   tagWord;
  logic [FRAME_W-1:0] frameWord;
  logic [FRAME_W-2:0] shiftReg;

  // Tag: global valid, per-slot flags, reserved zeros, address
  always_comb begin
    tagWord                = '0;
    tagWord[TAG_W-1]       = |slotValid;
    tagWord[ADDR_W-1:0]    = codecAddr;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      tagWord[FLAG_HI - i] = slotValid[i];
    end
  end

  assign frameWord[FRAME_W-1 -: TAG_W] = tagWord;

  // Data slots: payload gated by its own valid flag
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign frameWord[FRAME_W-1-TAG_W-s*SLOT_W -: SLOT_W] =
      slotValid[s] ? slotData[s*SLOT_W +: SLOT_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataOut  <= 1'b0;
      syncOut  <= 1'b0;
    end else begin
      syncOut <= strobe.syncNext;
      if (strobe.load) begin
        dataOut  <= frameWord[FRAME_W-1];
        shiftReg <= frameWord[FRAME_W-2:0];
      end else begin
        dataOut  <= shiftReg[FRAME_W-2];
        shiftReg <= {shiftReg[FRAME_W-3:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/slot_frame_tx.sv
module slot_frame_tx
  import slot_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 20,
  parameter int TAG_W     = 16,
  parameter int ADDR_W    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SLOTS-1:0]        slotValid,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slotData,
  input  logic [ADDR_W-1:0]           codecAddr,
  output logic                        frameStart,
  output logic                        syncOut,
  output logic                        dataOut
);

  localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;

  txStrobe_t strobe;

  slot_tx_ctrl #(
    .TAG_W  (TAG_W),
    .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .frameStart(frameStart)
  );

  slot_tx_dp #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .TAG_W    (TAG_W),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .slotValid(slotValid),
    .slotData (slotData),
    .codecAddr(codecAddr),
    .syncOut  (syncOut),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/slot_frame_tx_chk.sv
module slot_frame_tx_chk #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 20,
  parameter int TAG_W     = 16,
  parameter int ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SLOTS-1:0] slotValid,
  input logic                 frameStart,
  input logic                 syncOut,
  input logic                 dataOut
);

  localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_W);
  localparam logic [CNT_W-1:0] RSV_POS  = CNT_W'(TAG_W - 1 - ADDR_W);

  // Observed position of the bit currently on dataOut
  logic [CNT_W-1:0]     outPos;
  logic                 started;
  logic [NUM_SLOTS-1:0] capMask;
  logic                 curValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPos  <= '0;
      started <= 1'b0;
      capMask <= '0;
    end else begin
      started <= started | frameStart;
      if (frameStart) begin
        outPos  <= '0;
        capMask <= slotValid;
      end else if (outPos != LAST_POS) begin
        outPos <= outPos + 1'b1;
      end
    end
  end

  always_comb begin
    curValid = 1'b1;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (int'(outPos) >= TAG_W + i * SLOT_W && int'(outPos) < TAG_W + (i + 1) * SLOT_W)
        curValid = capMask[i];
    end
  end

  // R2: sync follows the tag window
  a_r2_sync_window: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (syncOut == (outPos < TAG_END)));

  // R1: strobe is a single-cycle pulse
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  // R1: strobe appears while the last bit of a frame is on the line
  a_r1_strobe_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (started && outPos == LAST_POS) |-> frameStart);

  // R7: invalid slots are zero
  a_r7_invalid_zero: assert property (@(posedge clk) disable iff (!rstN)
    (started && !curValid) |-> !dataOut);

  // R5: reserved tag bit is zero
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (started && outPos == RSV_POS) |-> !dataOut);

  // R3: first bit is the OR of the captured flags
  a_r3_frame_valid: assert property (@(posedge clk) disable iff (!rstN)
    (started && outPos == '0) |-> (dataOut == (|capMask)));

endmodule

bind slot_frame_tx slot_frame_tx_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .SLOT_W   (SLOT_W),
  .TAG_W    (TAG_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotValid (slotValid),
  .frameStart(frameStart),
  .syncOut   (syncOut),
  .dataOut   (dataOut)
);

// File: tb/slot_frame_tx_bench.sv
module slot_frame_tx_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [11:0]  slotValid = '0;
  logic [239:0] slotData = '0;
  logic [1:0]   codecAddr = '0;
  logic         frameStart, syncOut, dataOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  slot_frame_tx u_slot_frame_tx (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotData(slotData),
    .codecAddr(codecAddr), .frameStart(frameStart), .syncOut(syncOut), .dataOut(dataOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [239:0] randData();
    logic [239:0] v;
    for (int i = 0; i < 8; i++) v[i*30 +: 30] = 30'($urandom);
    return v;
  endfunction

  // Sends one frame starting at a falling edge where frameStart is high
  task automatic runFrame(input logic [11:0] m, input logic [239:0] d,
                          input logic [1:0] a, input bit mid);
    logic [255:0] gotD, gotS, gotF;
    logic [15:0]  gotTag, expTag;
    logic [19:0]  gotSlot, expSlot;
    string        tg;
    check("R1 strobe before frame", 32'(frameStart), 32'd1);
    slotValid = m; slotData = d; codecAddr = a;
    for (int p = 0; p < 256; p++) begin
      @(posedge clk);
      @(negedge clk);
      gotD[p] = dataOut; gotS[p] = syncOut; gotF[p] = frameStart;
      if (mid && p == 40) begin
        slotValid = ~m; slotData = ~d; codecAddr = ~a;
      end
    end
    check("R1 strobe count", 32'($countones(gotF)), 32'd1);
    check("R1 strobe position", 32'(gotF[255]), 32'd1);
    check("R2 sync count", 32'($countones(gotS)), 32'd16);
    check("R2 sync tag window", 32'(gotS[15:0]), 32'hFFFF);
    for (int k = 0; k < 16; k++) gotTag[15-k] = gotD[k];
    expTag = '0;
    expTag[15] = (m != 0);
    for (int n = 1; n <= 12; n++) expTag[15-n] = m[n-1];
    expTag[1:0] = a;
    tg = mid ? "R8 tag after mid-frame change" : "R3 frame valid";
    check(tg, 32'(gotTag[15]), 32'(expTag[15]));
    check(mid ? "R8 flags" : "R4 slot flags", 32'(gotTag[14:3]), 32'(expTag[14:3]));
    check(mid ? "R8 addr" : "R5 reserved+addr", 32'(gotTag[2:0]), 32'(expTag[2:0]));
    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < 20; k++) gotSlot[19-k] = gotD[16 + i*20 + k];
      expSlot = m[i] ? d[i*20 +: 20] : 20'h0;
      tg = mid ? "R8 slot payload" : (m[i] ? "R6 slot payload" : "R7 invalid slot zero");
      check(tg, 32'(gotSlot), 32'(expSlot));
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R9 reset sync low", 32'(syncOut), 32'd0);
      check("R9 reset data low", 32'(dataOut), 32'd0);
    end
    rstN = 1'b1;
    // R9: first frame begins at the first edge after release
    runFrame(12'hFFF, randData(), 2'd3, 1'b0);
    runFrame(12'h000, {240{1'b1}}, 2'd2, 1'b0);
    for (int n = 0; n < 12; n++)
      runFrame(12'(1 << n), randData(), 2'(n), 1'b0);
    runFrame(12'hAAA, randData(), 2'd1, 1'b1);
    runFrame(12'h555, randData(), 2'd2, 1'b1);
    runFrame(12'h801, {240{1'b1}}, 2'd0, 1'b0);
    runFrame(12'hFFF, {240{1'b1}}, 2'd3, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule